// File: doc/BRIEF.md
# Unaligned Access Bus Sequencer

This block connects a processor load/store port to a memory that is 16 bits wide and addressed by byte over a 24-bit space. A request carries a size of one, two or four bytes and may begin at any byte address, odd ones included. The sequencer turns each request into the smallest run of back-to-back 16-bit bus cycles. Each cycle carries a word address and one enable per byte lane.

For a store, each operand byte is steered to the lane that holds its address. For a load, the lanes that come back are gathered into a 32-bit result. The byte at the starting address lands in bits [7:0], and the upper bits are zero-filled. Bytes follow little-endian order: the less significant byte is always at the lower address.

The memory answers a read with its data one cycle after the cycle that asked for it. The sequencer takes no new request until the bus cycles of the current one are done. A run that passes the top of the space continues at address zero.

Top module: `misalign_bus_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `mem_en` is 0 and `rsp_valid` is 0.
- R2: `req_size` 2'b00 means one byte, 2'b01 two bytes and 2'b1x four bytes. The number of bus cycles (`mem_en` high) is as follows:
  - a byte takes 1 cycle;
  - a two-byte request takes 1 cycle at an even address and 2 at an odd one;
  - a four-byte request takes 2 cycles at an even address and 3 at an odd one.
  The cycles are consecutive and begin in the cycle after acceptance. `mem_be` is never 0 while `mem_en` is high.
- R3: The first bus cycle drives `mem_waddr` = request address bits [23:1], and each later cycle drives the previous value plus one. `mem_be[0]` enables the byte at the even address, carried on data bits [7:0]. `mem_be[1]` enables the byte at the odd address, carried on bits [15:8].
- R4: A lane is enabled exactly when its byte belongs to the request:
  - a multi-byte request at an odd address has `mem_be`=2'b10 in its first cycle and 2'b01 in its last;
  - a multi-byte request at an even address has 2'b11 in every cycle;
  - a byte request enables only the lane given by address bit 0.
- R5: For a read, `rsp_valid` is high for exactly one cycle, two cycles after the last bus cycle. `rsp_rdata` byte k is the memory byte at start address + k for k < size, and the higher bytes are zero. Memory read data is taken one cycle after each bus cycle.
- R6: For a write, `mem_we` is 1 in every bus cycle. Each enabled lane carries request data byte k (bits [8k+7:8k]) for the byte at start address + k. A disabled lane carries zero. A write produces no `rsp_valid`.
- R7: `req_ready` is 0 from the cycle after acceptance through the last bus cycle, and is 1 again in the following cycle. A request presented while `req_ready` is 0 has no effect on the bus or the memory.
- R8: Byte addresses wrap modulo 2^24. A request whose bytes pass 24'hFFFFFF continues at address 0, and `mem_waddr` steps from 23'h7FFFFF to 0.
- R9: A new request may be accepted in the cycle in which the previous read's last data returns. Its first bus cycle then coincides with the previous read's `rsp_valid`, and both operations complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 two bytes, 1x four bytes |
| req_addr | input | 24 | Starting byte address |
| req_wdata | input | 32 | Write operand, byte 0 at the starting address |
| rsp_valid | output | 1 | Read result valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read result, zero-extended |
| mem_en | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_waddr | output | 23 | Word address of this bus cycle |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data per lane |
| mem_rdata | input | 16 | Read data, valid the cycle after a read bus cycle |

## Verification
Two things can fall in the same cycle.

- **Gather and accept.** The last byte gather of a read can coincide with the acceptance of the next request.
- **Respond and issue.** One cycle later, the read result is delivered while the new request drives its first bus cycle.

The bench provokes this by presenting a second read while the first odd-addressed four-byte read is still running, so that the second read is taken on the first cycle `req_ready` returns. It judges the outcome from the cycle stamps of the bus log and the response log. It also compares both returned values against a byte-level shadow of memory, which shows that the new request neither corrupts nor delays the result still being assembled.

// File: rtl/misalign_bus_seq.sv
module misalign_bus_seq #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-2:0] mem_waddr,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int WAW = AW - 1;

  function automatic logic lane_hit(input logic [1:0] i, input logic l,
                                    input logic a0, input logic [2:0] n);
    logic [2:0] pos;
    pos = {i, l};
    return (pos >= {2'b00, a0}) && ((pos - {2'b00, a0}) < n);
  endfunction

  function automatic logic [1:0] lane_idx(input logic [1:0] i, input logic l,
                                          input logic a0);
    logic [2:0] pos;
    pos = {i, l} - {2'b00, a0};
    return pos[1:0];
  endfunction

  logic          busy;
  logic [1:0]    cyc, last_idx;
  logic [AW-1:0] r_addr;
  logic [2:0]    r_n;
  logic          r_we;
  logic [31:0]   r_wdata;

  logic [2:0] req_n, span;
  logic       accept, last;
  logic       hit0, hit1;
  logic [1:0] idx0, idx1;

  assign req_n  = req_size[1] ? 3'd4 : (req_size[0] ? 3'd2 : 3'd1);
  assign span   = {2'b00, req_addr[0]} + req_n - 3'd1;
  assign accept = req_valid && req_ready;
  assign last   = (cyc == last_idx);

  assign hit0 = busy && lane_hit(cyc, 1'b0, r_addr[0], r_n);
  assign hit1 = busy && lane_hit(cyc, 1'b1, r_addr[0], r_n);
  assign idx0 = lane_idx(cyc, 1'b0, r_addr[0]);
  assign idx1 = lane_idx(cyc, 1'b1, r_addr[0]);

  assign req_ready = !busy;
  assign mem_en    = busy;
  assign mem_we    = busy && r_we;
  assign mem_waddr = r_addr[AW-1:1] + {{(WAW-2){1'b0}}, cyc};
  assign mem_be    = {hit1, hit0};
  assign mem_wdata[7:0]  = (hit0 && r_we) ? r_wdata[{idx0, 3'b000} +: 8] : 8'h00;
  assign mem_wdata[15:8] = (hit1 && r_we) ? r_wdata[{idx1, 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cyc      <= '0;
      last_idx <= '0;
      r_addr   <= '0;
      r_n      <= 3'd1;
      r_we     <= 1'b0;
      r_wdata  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cyc      <= '0;
      last_idx <= span[2:1];
      r_addr   <= req_addr;
      r_n      <= req_n;
      r_we     <= req_write;
      r_wdata  <= req_wdata;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cyc  <= cyc + 2'd1;
    end
  end

  logic        p_vld, p_last;
  logic [1:0]  p_be, p_j0, p_j1;
  logic [31:0] acc, merged;

  always_comb begin
    merged = acc;
    if (p_be[0]) merged[{p_j0, 3'b000} +: 8] = mem_rdata[7:0];
    if (p_be[1]) merged[{p_j1, 3'b000} +: 8] = mem_rdata[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld     <= 1'b0;
      p_last    <= 1'b0;
      p_be      <= '0;
      p_j0      <= '0;
      p_j1      <= '0;
      acc       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      p_vld     <= busy && !r_we;
      p_last    <= last;
      p_be      <= mem_be;
      p_j0      <= idx0;
      p_j1      <= idx1;
      rsp_valid <= p_vld && p_last;
      if (p_vld) begin
        if (p_last) begin
          rsp_rdata <= merged;
          acc       <= '0;
        end else begin
          acc <= merged;
        end
      end
    end
  end

  AST_BE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_be != 2'b00);  // R2
  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !last) |=> (mem_en && mem_waddr == $past(mem_waddr) + 1'b1));  // R3
  AST_ODD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr[0] && req_size != 2'b00) |=> mem_be == 2'b10);  // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R5
  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);  // R7
endmodule

// File: tb/misalign_bus_seq_bench.sv
module misalign_bus_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_en, mem_we;
  logic [31:0] rsp_rdata;
  logic [22:0] mem_waddr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  misalign_bus_seq u_misalign_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [7:0] pat(input int b);
    return 8'(b * 37 + 11);
  endfunction

  logic [15:0] mem [256];
  logic [15:0] rd_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= {pat(2*i+1), pat(2*i)};
      rd_q <= '0;
    end else if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_waddr[7:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_waddr[7:0]][15:8] <= mem_wdata[15:8];
      end else begin
        rd_q <= mem[mem_waddr[7:0]];
      end
    end
  end

  logic [7:0] shadow [512];
  int tcnt = 0;
  always @(posedge clk) tcnt <= tcnt + 1;

  logic [22:0] log_addr [128];
  logic [1:0]  log_be [128];
  logic        log_we [128];
  logic [15:0] log_wd [128];
  int          log_t [128];
  logic [31:0] rsp_d [32];
  int          rsp_t [32];
  int log_n = 0, rsp_n = 0, ready_viol = 0;
  always @(negedge clk) begin
    if (rst_n && mem_en && log_n < 128) begin
      log_addr[log_n] <= mem_waddr; log_be[log_n] <= mem_be;
      log_we[log_n] <= mem_we; log_wd[log_n] <= mem_wdata;
      log_t[log_n] <= tcnt; log_n <= log_n + 1;
      if (req_ready) ready_viol <= ready_viol + 1;
    end
    if (rst_n && rsp_valid && rsp_n < 32) begin
      rsp_d[rsp_n] <= rsp_rdata; rsp_t[rsp_n] <= tcnt; rsp_n <= rsp_n + 1;
    end
  end

  int nchk = 0, nfail = 0;
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] size);
    return size[1] ? 4 : (size[0] ? 2 : 1);
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] size, input logic [23:0] addr);
    logic [31:0] d;
    logic [23:0] ba;
    d = '0;
    for (int j = 0; j < nbytes(size); j++) begin
      ba = addr + 24'(j);
      d[8*j +: 8] = shadow[ba[8:0]];
    end
    return d;
  endfunction

  task automatic do_req(input logic we, input logic [1:0] size, input logic [23:0] addr,
                        input logic [31:0] wd);
    req_valid = 1'b1; req_write = we; req_size = size; req_addr = addr; req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic run_access(input logic we, input logic [1:0] size, input logic [23:0] addr,
                            input logic [31:0] wd);
    int s0, r0, ncy, c;
    logic [1:0]  ebe [4];
    logic [15:0] ewd [4];
    logic [23:0] ba;
    logic [31:0] erd;
    s0 = log_n; r0 = rsp_n; ncy = 0;
    for (int k = 0; k < 4; k++) begin ebe[k] = 2'b00; ewd[k] = 16'h0; end
    erd = exp_read(size, addr);
    do_req(we, size, addr, wd);
    wait_idle();
    for (int j = 0; j < nbytes(size); j++) begin
      ba = addr + 24'(j);
      c = int'(23'(ba[23:1] - addr[23:1]));
      ebe[c][ba[0]] = 1'b1;
      ewd[c][8*ba[0] +: 8] = wd[8*j +: 8];
      if (c + 1 > ncy) ncy = c + 1;
      if (we) shadow[ba[8:0]] = wd[8*j +: 8];
    end
    check("R2 bus cycle count", 32'(log_n - s0), 32'(ncy));
    for (int k = 0; k < ncy; k++) begin
      check("R3 word address", 32'(log_addr[s0+k]), 32'(23'(addr[23:1] + 23'(k))));
      check("R4 byte enables", 32'(log_be[s0+k]), 32'(ebe[k]));
      check("R6 write strobe", 32'(log_we[s0+k]), 32'(we));
      if (we) check("R6 lane data", 32'(log_wd[s0+k]), 32'(ewd[k]));
    end
    if (we) begin
      check("R6 no response on write", 32'(rsp_n - r0), 32'd0);
    end else begin
      check("R5 response count", 32'(rsp_n - r0), 32'd1);
      check("R5 read data", rsp_d[r0], erd);
      check("R5 response timing", 32'(rsp_t[r0]), 32'(log_t[s0+ncy-1] + 2));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ready in reset", 32'(req_ready), 32'd1);
    check("R1 bus idle in reset", 32'(mem_en), 32'd0);
    check("R1 no response in reset", 32'(rsp_valid), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 bus idle after reset", 32'(mem_en), 32'd0);
    @(posedge clk); #1;
  endtask

  task automatic t_aligned();
    run_access(1'b0, 2'b00, 24'h000010, '0);
    run_access(1'b0, 2'b00, 24'h000011, '0);
    run_access(1'b0, 2'b01, 24'h000020, '0);
    run_access(1'b0, 2'b10, 24'h000030, '0);
    run_access(1'b1, 2'b01, 24'h000040, 32'hDEAD_BEEF);
    run_access(1'b1, 2'b00, 24'h000043, 32'h0000_00C3);
    run_access(1'b1, 2'b10, 24'h000048, 32'h1234_5678);
    run_access(1'b0, 2'b10, 24'h000040, '0);
    run_access(1'b0, 2'b11, 24'h000048, '0);
  endtask

  task automatic t_odd();
    run_access(1'b0, 2'b01, 24'h000051, '0);
    run_access(1'b0, 2'b10, 24'h000061, '0);
    run_access(1'b1, 2'b01, 24'h000071, 32'h0000_A55A);
    run_access(1'b1, 2'b10, 24'h000083, 32'hCAFE_F00D);
    run_access(1'b0, 2'b10, 24'h000070, '0);
    run_access(1'b0, 2'b10, 24'h000083, '0);
    run_access(1'b0, 2'b01, 24'h000086, '0);
  endtask

  task automatic t_wrap();
    int s0;
    s0 = log_n;
    run_access(1'b0, 2'b10, 24'hFFFFFF, '0);
    check("R8 wrap to word 0", 32'(log_addr[s0+1]), 32'd0);
    check("R8 start at top word", 32'(log_addr[s0]), 32'h7FFFFF);
    s0 = log_n;
    run_access(1'b1, 2'b01, 24'hFFFFFF, 32'h0000_9E81);
    check("R8 wrapped write word", 32'(log_addr[s0+1]), 32'd0);
    run_access(1'b0, 2'b10, 24'hFFFFFE, '0);
  endtask

  task automatic t_ignore();
    int s0;
    s0 = log_n;
    do_req(1'b0, 2'b10, 24'h000091, '0);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10;
    req_addr = 24'h000091; req_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_idle();
    check("R7 stray request adds no cycles", 32'(log_n - s0), 32'd3);
    check("R7 ready low during bus cycles", 32'(ready_viol), 32'd0);
    run_access(1'b0, 2'b10, 24'h000091, '0);
  endtask

  task automatic t_overlap();
    int s0, r0;
    logic [31:0] e1, e2;
    s0 = log_n; r0 = rsp_n;
    e1 = exp_read(2'b10, 24'h0000A1);
    e2 = exp_read(2'b01, 24'h0000B3);
    do_req(1'b0, 2'b10, 24'h0000A1, '0);
    do_req(1'b0, 2'b01, 24'h0000B3, '0);
    wait_idle();
    check("R9 total bus cycles", 32'(log_n - s0), 32'd5);
    check("R9 new request starts two cycles after last", 32'(log_t[s0+3]), 32'(log_t[s0+2] + 2));
    check("R9 response count", 32'(rsp_n - r0), 32'd2);
    check("R9 first result", rsp_d[r0], e1);
    check("R9 response with new bus cycle", 32'(rsp_t[r0]), 32'(log_t[s0+3]));
    check("R9 second result", rsp_d[r0+1], e2);
  endtask

  initial begin
    for (int b = 0; b < 512; b++) shadow[b] = pat(b);
    t_reset();
    t_aligned();
    t_odd();
    t_wrap();
    t_ignore();
    t_overlap();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule